// File: doc/BRIEF.md
# Packed Pixel SRAM Bank Controller

This block sits between byte-wide pixel streams and one 32-bit synchronous pipelined SRAM bank with no bus turnaround penalty. Pixels of one image are stored four to a memory word in scan order, so a frame costs a quarter of the memory accesses that a one-pixel-per-word layout would. The write side gathers four pixels and issues a single word write. When a frame ends partway through a word, it issues a partial write that enables only the filled byte lanes. The read side is started by a command that carries a word address and a pixel count. It fetches words back to back and hands the pixels out one per cycle in their original order.

The SRAM bank accepts a command every cycle. Write data follows its command by two cycles, and read data returns two cycles after the read command. The controller keeps its address counters, byte lanes, byte enables and write-data pipeline aligned with that timing. One instance drives exactly one bank. The four parity bits of the memory device are not connected. Completed write words take the command slot ahead of reads. Reads fill the remaining slots, and a small word queue keeps the pixel output free of gaps.

Top module: `pix_sram_ctrl`

## Requirements
- R1: After reset, chip select and write enable are high (inactive), the data bus is not driven, no pixel is offered on the read stream and the read side is not busy; in any cycle with no command, chip select stays high.
- R2: Written pixel k of a frame goes to word address base + k/4, byte lane k mod 4 (lane 0 is bits 7:0 and holds the earliest pixel); each group of four pixels produces exactly one write command.
- R3: Write data is driven onto the bus, and the bus output enable is high, exactly two cycles after the cycle in which its write command is on the pins, and at no other time.
- R4: A frame whose pixel count is not a multiple of four ends with one write command whose active-low byte enables select only the filled lanes; the other bytes of that word keep their previous contents; every write command enables at least one lane.
- R5: A read of N pixels from word address B delivers, in order, lane 0 to lane 3 of word B, then of word B+1, and so on, with data taken from the bus two cycles after each read command.
- R6: A read delivers exactly N pixels, and the last-pixel flag is high on the Nth pixel only, including when N is not a multiple of four; afterwards no pixel is offered and the read side is idle.
- R7: With the output stream held ready and no writes pending, the pixels of a read come out on consecutive cycles with no gap.
- R8: While a pixel is offered and not accepted, the pixel value and its last flag stay unchanged.
- R9: A read start command issued while the read side is busy is ignored; the running read continues with its original address and count.
- R10: A write word always takes the command slot over a pending read (its write command appears on the next cycle); reads and writes in flight at the same time both complete correctly.
- R11: Each write frame starts at the write base address sampled with its first pixel, including the frame that follows a completed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SRAM bank |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write pixel present this cycle |
| wr_pixel | input | 8 | Write pixel value |
| wr_last | input | 1 | Write pixel is the final one of its frame |
| wr_base | input | 19 | Word address of the frame, sampled with its first pixel |
| rd_start | input | 1 | Start a read (ignored while busy) |
| rd_base | input | 19 | First word address of the read |
| rd_npix | input | 21 | Number of pixels to read |
| rd_busy | output | 1 | Read in progress |
| rd_valid | output | 1 | Read pixel offered |
| rd_ready | input | 1 | Consumer accepts the offered pixel |
| rd_pixel | output | 8 | Read pixel value |
| rd_last | output | 1 | Offered pixel is the last of the read |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_addr | output | 19 | Word address |
| sram_bw_n | output | 4 | Byte write enables, active low, bit k for lane k |
| sram_dq_out | output | 32 | Write data to the bus |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_in | input | 32 | Read data from the bus |

## Verification
The hardest situation to reach is a read and a write frame overlapping in time. In that case the write words take command slots from the read stream, and the delayed data pipelines of both directions are in flight together. The bench forks a write frame and a read that start on the same edge, then checks the read pixels and reads the new frame back. A second hard case is a restart request that arrives while a stalled read still holds queued words. The bench stalls the consumer, issues a start with a different address, and then checks that only the first read's pixels come out.

// File: rtl/pix_sram_pkg.sv
package pix_sram_pkg;
  parameter int PIX_W  = 8;
  parameter int LANES  = 4;
  parameter int WORD_W = PIX_W * LANES;

  // number of packed words needed for npix pixels
  function automatic logic [31:0] words_for(input logic [31:0] npix);
    return (npix + 32'(LANES - 1)) / 32'(LANES);
  endfunction

  // one-hot enable of a byte lane
  function automatic logic [LANES-1:0] lane_bit(input int unsigned lane);
    return LANES'(1) << lane;
  endfunction

  // replace one lane of a word with a pixel
  function automatic logic [WORD_W-1:0] put_pixel(input logic [WORD_W-1:0] w,
                                                  input int unsigned lane,
                                                  input logic [PIX_W-1:0] p);
    logic [WORD_W-1:0] r;
    r = w;
    r[lane*PIX_W +: PIX_W] = p;
    return r;
  endfunction

  // extract one lane of a word
  function automatic logic [PIX_W-1:0] get_pixel(input logic [WORD_W-1:0] w,
                                                 input int unsigned lane);
    return w[lane*PIX_W +: PIX_W];
  endfunction
endpackage

// File: rtl/pix_wr_pack.sv
module pix_wr_pack
  import pix_sram_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [PIX_W-1:0]  wr_pixel,
  input  logic              wr_last,
  input  logic [ADDR_W-1:0] wr_base,
  output logic              word_fire,
  output logic [ADDR_W-1:0] word_addr,
  output logic [WORD_W-1:0] word_data,
  output logic [LANES-1:0]  word_be
);
  localparam int LANE_W = $clog2(LANES);

  logic [LANE_W-1:0] lane_q;
  logic [WORD_W-1:0] acc_q;
  logic [LANES-1:0]  be_q;
  logic [ADDR_W-1:0] addr_q;
  logic              first_q;

  // the word being assembled, including the pixel on the input this cycle
  always_comb begin
    word_addr = first_q ? wr_base : addr_q;
    word_data = put_pixel(acc_q, int'(lane_q), wr_pixel);
    word_be   = be_q | lane_bit(int'(lane_q));
    word_fire = wr_valid && ((lane_q == LANE_W'(LANES - 1)) || wr_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q  <= '0;
      acc_q   <= '0;
      be_q    <= '0;
      addr_q  <= '0;
      first_q <= 1'b1;
    end else if (wr_valid) begin
      if (word_fire) begin
        lane_q <= '0;
        acc_q  <= '0;
        be_q   <= '0;
        addr_q <= word_addr + 1'b1;
      end else begin
        lane_q <= lane_q + 1'b1;
        acc_q  <= word_data;
        be_q   <= word_be;
        addr_q <= word_addr;
      end
      first_q <= wr_last;
    end
  end
endmodule

// File: rtl/pix_rd_fetch.sv
module pix_rd_fetch #(
  parameter int ADDR_W     = 19,
  parameter int CNT_W      = 21,
  parameter int RD_LAT     = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int LVL_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  nwords,
  input  logic              grant,
  input  logic [LVL_W-1:0]  level,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic              capture,
  output logic              busy
);
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_q;
  logic [RD_LAT:0]   pipe_q;   // bit 0: command on the pins, bit RD_LAT: data on the bus
  int                pend;

  always_comb begin
    pend    = int'(level) + $countones(pipe_q);
    req     = (left_q != '0) && (pend < FIFO_DEPTH);
    addr    = addr_q;
    capture = pipe_q[RD_LAT];
    busy    = (left_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      addr_q <= '0;
      pipe_q <= '0;
    end else begin
      pipe_q <= {pipe_q[RD_LAT-1:0], grant};
      if (start) begin
        left_q <= nwords;
        addr_q <= base;
      end else if (grant) begin
        left_q <= left_q - 1'b1;
        addr_q <= addr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pix_rd_unpack.sv
module pix_rd_unpack
  import pix_sram_pkg::*;
#(
  parameter int CNT_W      = 21,
  parameter int FIFO_DEPTH = 4,
  parameter int LVL_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  npix,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [PIX_W-1:0]  rd_pixel,
  output logic              rd_last,
  output logic [LVL_W-1:0]  level,
  output logic              busy
);
  localparam int PTR_W  = $clog2(FIFO_DEPTH);
  localparam int LANE_W = $clog2(LANES);

  logic [WORD_W-1:0] mem_q [FIFO_DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [LVL_W-1:0]  level_q;
  logic [LANE_W-1:0] lane_q;
  logic [CNT_W-1:0]  left_q;
  logic              fire, pop;

  always_comb begin
    rd_valid = (level_q != '0) && (left_q != '0);
    rd_pixel = get_pixel(mem_q[rptr_q], int'(lane_q));
    rd_last  = rd_valid && (left_q == CNT_W'(1));
    fire     = rd_valid && rd_ready;
    pop      = fire && ((lane_q == LANE_W'(LANES - 1)) || (left_q == CNT_W'(1)));
    level    = level_q;
    busy     = (left_q != '0);
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wptr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
      lane_q  <= '0;
      left_q  <= '0;
    end else begin
      if (push) wptr_q <= wptr_q + 1'b1;
      if (pop)  rptr_q <= rptr_q + 1'b1;
      case ({push, pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
      if (start) begin
        left_q <= npix;
        lane_q <= '0;
      end else if (fire) begin
        left_q <= left_q - 1'b1;
        lane_q <= pop ? '0 : lane_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pix_sram_ctrl.sv
module pix_sram_ctrl
  import pix_sram_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int WR_LAT     = 2,
  parameter int RD_LAT     = 2,
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W     = ADDR_W + $clog2(LANES),
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [PIX_W-1:0]  wr_pixel,
  input  logic              wr_last,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_base,
  input  logic [CNT_W-1:0]  rd_npix,
  output logic              rd_busy,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [PIX_W-1:0]  rd_pixel,
  output logic              rd_last,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [LANES-1:0]  sram_bw_n,
  output logic [WORD_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [WORD_W-1:0] sram_dq_in
);
  // named internal events
  logic              wr_word_fire;
  logic [ADDR_W-1:0] wr_word_addr;
  logic [WORD_W-1:0] wr_word_data;
  logic [LANES-1:0]  wr_word_be;
  logic              rd_req, rd_grant, rd_capture, rd_start_acc;
  logic [ADDR_W-1:0] rd_addr;
  logic [LVL_W-1:0]  rd_level;
  logic              fetch_busy, unpack_busy;
  logic [CNT_W-1:0]  rd_nwords;

  assign rd_busy      = fetch_busy || unpack_busy;
  assign rd_start_acc = rd_start && !rd_busy;
  assign rd_nwords    = CNT_W'(words_for(32'(rd_npix)));
  assign rd_grant     = rd_req && !wr_word_fire;   // writes own the slot

  pix_wr_pack #(.ADDR_W(ADDR_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_pixel  (wr_pixel),
    .wr_last   (wr_last),
    .wr_base   (wr_base),
    .word_fire (wr_word_fire),
    .word_addr (wr_word_addr),
    .word_data (wr_word_data),
    .word_be   (wr_word_be)
  );

  pix_rd_fetch #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RD_LAT(RD_LAT),
    .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
  ) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (rd_start_acc),
    .base    (rd_base),
    .nwords  (rd_nwords),
    .grant   (rd_grant),
    .level   (rd_level),
    .req     (rd_req),
    .addr    (rd_addr),
    .capture (rd_capture),
    .busy    (fetch_busy)
  );

  pix_rd_unpack #(
    .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
  ) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (rd_start_acc),
    .npix      (rd_npix),
    .push      (rd_capture),
    .push_data (sram_dq_in),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_pixel  (rd_pixel),
    .rd_last   (rd_last),
    .level     (rd_level),
    .busy      (unpack_busy)
  );

  // command pins, registered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_cs_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_addr <= '0;
      sram_bw_n <= '1;
    end else if (wr_word_fire) begin
      sram_cs_n <= 1'b0;
      sram_we_n <= 1'b0;
      sram_addr <= wr_word_addr;
      sram_bw_n <= ~wr_word_be;
    end else if (rd_grant) begin
      sram_cs_n <= 1'b0;
      sram_we_n <= 1'b1;
      sram_addr <= rd_addr;
      sram_bw_n <= '1;
    end else begin
      sram_cs_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_bw_n <= '1;
    end
  end

  // write data delay line: stage 0 lines up with the command on the pins
  logic [WORD_W-1:0] wd_q [WR_LAT+1];
  logic [WR_LAT:0]   woe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      woe_q <= '0;
      for (int i = 0; i <= WR_LAT; i++) wd_q[i] <= '0;
    end else begin
      woe_q   <= {woe_q[WR_LAT-1:0], wr_word_fire};
      wd_q[0] <= wr_word_data;
      for (int i = 1; i <= WR_LAT; i++) wd_q[i] <= wd_q[i-1];
    end
  end

  assign sram_dq_out = wd_q[WR_LAT];
  assign sram_dq_oe  = woe_q[WR_LAT];
endmodule

// File: rtl/pix_sram_ctrl_chk.sv
module pix_sram_ctrl_chk #(
  parameter int WR_LAT = 2,
  parameter int LANES  = 4,
  parameter int PIX_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sram_cs_n,
  input logic             sram_we_n,
  input logic [LANES-1:0] sram_bw_n,
  input logic             sram_dq_oe,
  input logic             rd_start,
  input logic             rd_busy,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [PIX_W-1:0] rd_pixel,
  input logic             rd_last,
  input logic             wr_word_fire,
  input logic             rd_grant
);
  // history of write commands seen on the pins
  logic [WR_LAT-1:0] wcmd_sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcmd_sh <= '0;
    else        wcmd_sh <= (wcmd_sh << 1) | WR_LAT'(!sram_cs_n && !sram_we_n);
  end

  a_r3_wdata_lag: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe == wcmd_sh[WR_LAT-1]);

  a_r4_write_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && !sram_we_n) |-> (sram_bw_n != '1));

  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_pixel) && $stable(rd_last)));

  a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_word_fire |=> (!sram_cs_n && !sram_we_n));

  a_r9_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && rd_start && !rd_valid) |=> rd_busy);

  a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_word_fire && !rd_grant) |=> sram_cs_n);
endmodule

bind pix_sram_ctrl pix_sram_ctrl_chk #(
  .WR_LAT(WR_LAT), .LANES(LANES), .PIX_W(PIX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sram_cs_n    (sram_cs_n),
  .sram_we_n    (sram_we_n),
  .sram_bw_n    (sram_bw_n),
  .sram_dq_oe   (sram_dq_oe),
  .rd_start     (rd_start),
  .rd_busy      (rd_busy),
  .rd_valid     (rd_valid),
  .rd_ready     (rd_ready),
  .rd_pixel     (rd_pixel),
  .rd_last      (rd_last),
  .wr_word_fire (wr_word_fire),
  .rd_grant     (rd_grant)
);

// File: tb/sim_pix_sram_ctrl.sv
module sim_pix_sram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_last = 1'b0;
  logic [7:0]  wr_pixel = '0;
  logic [18:0] wr_base = '0;
  logic        rd_start = 1'b0, rd_ready = 1'b0;
  logic [18:0] rd_base = '0;
  logic [20:0] rd_npix = '0;
  logic        rd_busy, rd_valid, rd_last;
  logic [7:0]  rd_pixel;
  logic        sram_cs_n, sram_we_n, sram_dq_oe;
  logic [18:0] sram_addr;
  logic [3:0]  sram_bw_n;
  logic [31:0] sram_dq_out;
  logic [31:0] sram_dq_in = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pix_sram_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_pixel(wr_pixel), .wr_last(wr_last), .wr_base(wr_base),
    .rd_start(rd_start), .rd_base(rd_base), .rd_npix(rd_npix), .rd_busy(rd_busy),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_pixel(rd_pixel), .rd_last(rd_last),
    .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_addr(sram_addr),
    .sram_bw_n(sram_bw_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  function automatic logic [7:0] pix(input int s, input int i);
    return 8'(s * 37 + i * 11 + 3);
  endfunction

  function automatic logic [31:0] pre(input int i);
    return 32'(i) * 32'h0103_0507 + 32'h1122_3344;
  endfunction

  // behavioural bank: command sampled at edge n, data at edge n+2
  logic [31:0] mem [256];
  logic        s1_v = 0, s1_we = 0, s2_v = 0, s2_we = 0;
  logic [7:0]  s1_a = 0, s2_a = 0;
  logic [3:0]  s1_bw = 0, s2_bw = 0;
  int          wr_cmds = 0, oe_err = 0;
  logic [18:0] last_wr_addr = '0;

  initial for (int i = 0; i < 256; i++) mem[i] = pre(i);

  always @(posedge clk) begin
    if (rst_n) begin
      if (s2_v && s2_we) begin
        if (sram_dq_oe !== 1'b1) oe_err++;
        for (int k = 0; k < 4; k++)
          if (!s2_bw[k]) mem[s2_a][k*8 +: 8] = sram_dq_out[k*8 +: 8];
      end else if (sram_dq_oe === 1'b1) oe_err++;
      if (s1_v && !s1_we) sram_dq_in <= mem[s1_a];
      else                sram_dq_in <= 32'hDEAD_BEEF;
      s2_v = s1_v; s2_we = s1_we; s2_a = s1_a; s2_bw = s1_bw;
      s1_v  = (sram_cs_n === 1'b0);
      s1_we = (sram_we_n === 1'b0);
      s1_a  = sram_addr[7:0];
      s1_bw = sram_bw_n;
      if (s1_v && s1_we) begin
        wr_cmds++;
        last_wr_addr = sram_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FIFO FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [7:0] exp_pix [64];
  int first_c, last_c, got;

  task automatic write_frame(input int base, input int n, input int seed);
    @(negedge clk);
    wr_base = 19'(base);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1;
      wr_pixel = pix(seed, i);
      wr_last  = (i == n - 1);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    wr_last  = 1'b0;
  endtask

  task automatic start_read(input int base, input int n);
    @(negedge clk);
    rd_base  = 19'(base);
    rd_npix  = 21'(n);
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
  endtask

  task automatic collect(input int n, input bit stall, input string tag);
    int cyc;
    cyc = 0; got = 0; first_c = -1; last_c = -1;
    while (got < n && cyc < 2000) begin
      rd_ready = stall ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (rd_valid && rd_ready) begin
        chk(rd_pixel == exp_pix[got], {tag, " R5 pixel order"}, rd_pixel, exp_pix[got]);
        chk(rd_last == (got == n - 1), {tag, " R6 last flag"}, rd_last, got == n - 1);
        if (first_c < 0) first_c = cyc;
        last_c = cyc;
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    rd_ready = 1'b0;
    chk(got == n, {tag, " R6 pixel count"}, got, n);
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk(sram_cs_n == 1'b1, "R1 cs idle", sram_cs_n, 1);
    chk(sram_we_n == 1'b1, "R1 we idle", sram_we_n, 1);
    chk(sram_dq_oe == 1'b0, "R1 bus idle", sram_dq_oe, 0);
    chk(rd_valid == 1'b0 && rd_busy == 1'b0, "R1 read idle", {rd_valid, rd_busy}, 0);
  endtask

  task automatic t_full_frame;
    int c0;
    c0 = wr_cmds;
    write_frame(32'h20, 16, 1);
    idle_wait(6);
    chk(wr_cmds - c0 == 4, "R2 one write per four pixels", wr_cmds - c0, 4);
    chk(mem[8'h20] == {pix(1,3), pix(1,2), pix(1,1), pix(1,0)}, "R2 lane packing",
        mem[8'h20], {pix(1,3), pix(1,2), pix(1,1), pix(1,0)});
    chk(last_wr_addr == 19'h23, "R2 word address", last_wr_addr, 32'h23);
    chk(oe_err == 0, "R3 write data two cycles after command", oe_err, 0);
    for (int i = 0; i < 16; i++) exp_pix[i] = pix(1, i);
    start_read(32'h20, 16);
    collect(16, 1'b0, "full");
    chk(last_c - first_c == 15, "R7 no gaps", last_c - first_c, 15);
  endtask

  task automatic t_partial;
    int c0;
    logic [31:0] w41;
    c0 = wr_cmds;
    write_frame(32'h40, 6, 2);
    idle_wait(6);
    chk(wr_cmds - c0 == 2, "R4 partial word count", wr_cmds - c0, 2);
    w41 = {pre(32'h41) >> 16}[15:0] << 16 | {16'h0, pix(2,5), pix(2,4)};
    chk(mem[8'h41] == w41, "R4 unfilled lanes kept", mem[8'h41], w41);
    for (int i = 0; i < 6; i++) exp_pix[i] = pix(2, i);
    exp_pix[6] = pre(32'h41) >> 16;
    exp_pix[7] = pre(32'h41) >> 24;
    start_read(32'h40, 8);
    collect(8, 1'b0, "partial");
  endtask

  task automatic t_stall_odd;
    for (int i = 0; i < 7; i++) exp_pix[i] = pix(1, i);
    start_read(32'h20, 7);
    collect(7, 1'b1, "stall");
    idle_wait(3);
    #1;
    chk(rd_valid == 1'b0 && rd_busy == 1'b0, "R6 idle after last", {rd_valid, rd_busy}, 0);
  endtask

  task automatic t_restart_ignored;
    for (int i = 0; i < 5; i++) exp_pix[i] = pix(1, i);
    start_read(32'h20, 5);
    idle_wait(6);
    chk(rd_busy == 1'b1, "R9 busy while stalled", rd_busy, 1);
    start_read(32'h40, 9);
    collect(5, 1'b0, "restart R9");
    idle_wait(4);
    #1;
    chk(rd_valid == 1'b0 && rd_busy == 1'b0, "R9 second start dropped", {rd_valid, rd_busy}, 0);
  endtask

  task automatic t_overlap;
    for (int i = 0; i < 16; i++) exp_pix[i] = pix(1, i);
    fork
      write_frame(32'h60, 20, 3);
      begin
        start_read(32'h20, 16);
        collect(16, 1'b0, "overlap R10");
      end
    join
    idle_wait(6);
    for (int i = 0; i < 20; i++) exp_pix[i] = pix(3, i);
    start_read(32'h60, 20);
    collect(20, 1'b0, "overlap readback R10");
    chk(oe_err == 0, "R3 bus timing under overlap", oe_err, 0);
  endtask

  task automatic t_next_frame_base;
    write_frame(32'h80, 4, 4);
    idle_wait(6);
    chk(last_wr_addr == 19'h80, "R11 new frame base", last_wr_addr, 32'h80);
    chk(mem[8'h80] == {pix(4,3), pix(4,2), pix(4,1), pix(4,0)}, "R11 new frame data",
        mem[8'h80], {pix(4,3), pix(4,2), pix(4,1), pix(4,0)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_frame();
    t_partial();
    t_stall_odd();
    t_restart_ignored();
    t_overlap();
    t_next_frame_base();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule